// File: doc/BRIEF.md
# Bus-Multiplexed Up/Down Binary Counter

This block is a synchronous binary counter, eight bits wide by default, that can count up or down. One shared bus port carries both the load value going in and the count value coming out. Because a tri-state pin is not usable inside a synthesized core, the bus is modelled as three signals. `bus_in` is the sampled bus. `bus_out` is the value offered to the bus. `bus_oe` enables the drive.

All controls are active low. The priority runs from the asynchronous clear, to the clocked clear, to the parallel load, and then to hold or count. A select input gates the bus. While the load is selected, the block never drives the bus. Several counters can be chained into a wider one. A stage's terminal-count output feeds the trickle enable of the next stage. That trickle enable also gates the terminal count itself.

Top module: `bmc_counter`

## Requirements
- R1: While `rst_n` is low, the count is zero at once, with no clock edge needed and whatever the other inputs are.
- R2: With `rst_n` high and `sclr_n` low at a rising edge, the count becomes zero. This takes priority over load and count.
- R3: With both resets inactive and both `sel_n` and `ld_n` low at a rising edge, the count takes the value of `bus_in`.
- R4: `bus_oe` is high only when `sel_n` is low, `ld_n` is high and `oe_n` is low. In every other combination it is low, and it is never high while a load is selected. `bus_out` always shows the present count.
- R5: With `sel_n` high, a low `ld_n` loads nothing. The counter then holds or counts according to its enables.
- R6: With no reset or load active, the count holds whenever `cnt_en_n` is high or `chain_en_n` is high.
- R7: When both `cnt_en_n` and `chain_en_n` are low, the count rises by one if `up_dn` is 1 and falls by one if `up_dn` is 0. The count wraps modulo 2^W, so 8'hFF goes to 8'h00 when counting up and 8'h00 goes to 8'hFF when counting down.
- R8: `tc_n` is low exactly when `chain_en_n` is low and the count is at the end point for the selected direction: all ones when `up_dn` is 1, all zeros when `up_dn` is 0. `cnt_en_n` does not affect it, and it is high whenever `chain_en_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous clear, active low |
| sclr_n | input | 1 | Synchronous clear, active low |
| sel_n | input | 1 | Bus select, active low |
| ld_n | input | 1 | Parallel load request, active low |
| cnt_en_n | input | 1 | Local count enable, active low |
| chain_en_n | input | 1 | Cascade (trickle) count enable, active low |
| up_dn | input | 1 | Direction: 1 counts up, 0 counts down |
| oe_n | input | 1 | Bus drive enable, active low |
| bus_in | input | W | Value sampled from the shared bus |
| bus_out | output | W | Count value offered to the shared bus |
| bus_oe | output | 1 | High when the block drives the bus |
| tc_n | output | 1 | Terminal count, active low |

## Verification
A clocked clear can coincide with a parallel load, and a load request with `sel_n` high can coincide with enabled counting. The bench sets up both collisions in the same cycle. It expects zero in the first case and a counted value in the second, and it reads the result back over the bus. The bench also holds `chain_en_n` low with `cnt_en_n` high at an end value. There it expects `tc_n` low while the count stays frozen.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_CLEAR = 3'd1,
    OP_LOAD  = 3'd2,
    OP_UP    = 3'd3,
    OP_DOWN  = 3'd4
  } op_e;
endpackage

// File: rtl/bmc_ctrl.sv
module bmc_ctrl
  import bmc_pkg::*;
(
  input  logic sclr_n,
  input  logic sel_n,
  input  logic ld_n,
  input  logic cnt_en_n,
  input  logic chain_en_n,
  input  logic up_dn,
  input  logic oe_n,
  output op_e  op,
  output logic load_sel,
  output logic bus_oe
);
  logic count_go;

  assign load_sel = !sel_n && !ld_n;
  assign count_go = !cnt_en_n && !chain_en_n;
  assign bus_oe   = !sel_n && ld_n && !oe_n;

  always_comb begin
    if (!sclr_n)        op = OP_CLEAR;
    else if (load_sel)  op = OP_LOAD;
    else if (!count_go) op = OP_HOLD;
    else if (up_dn)     op = OP_UP;
    else                op = OP_DOWN;
  end
endmodule

// File: rtl/bmc_core.sv
module bmc_core
  import bmc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  op_e          op,
  input  logic [W-1:0] din,
  output logic [W-1:0] count
);
  function automatic logic [W-1:0] step(input logic [W-1:0] v, input logic up);
    return up ? W'(v + 1'b1) : W'(v - 1'b1);
  endfunction

  logic [W-1:0] nxt;

  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = din;
      OP_UP:    nxt = step(count, 1'b1);
      OP_DOWN:  nxt = step(count, 1'b0);
      default:  nxt = count;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= nxt;
  end

  // R2
  sclr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_CLEAR |=> count == '0);
  // R3
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_LOAD |=> count == $past(din));
  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_HOLD |=> $stable(count));
  // R7
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_UP |=> count - $past(count) == W'(1));
  // R7
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_DOWN |=> $past(count) - count == W'(1));
endmodule

// File: rtl/bmc_term.sv
module bmc_term #(
  parameter int W = 8
) (
  input  logic [W-1:0] count,
  input  logic         up_dn,
  input  logic         chain_en_n,
  output logic         tc_n
);
  function automatic logic at_end(input logic [W-1:0] v, input logic up);
    return up ? (&v) : (~|v);
  endfunction

  assign tc_n = !(!chain_en_n && at_end(count, up_dn));
endmodule

// File: rtl/bmc_counter.sv
module bmc_counter
  import bmc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclr_n,
  input  logic         sel_n,
  input  logic         ld_n,
  input  logic         cnt_en_n,
  input  logic         chain_en_n,
  input  logic         up_dn,
  input  logic         oe_n,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] bus_out,
  output logic         bus_oe,
  output logic         tc_n
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  op_e          op;
  logic         load_sel;
  logic [W-1:0] count;

  bmc_ctrl u_ctrl (
    .sclr_n(sclr_n), .sel_n(sel_n), .ld_n(ld_n), .cnt_en_n(cnt_en_n),
    .chain_en_n(chain_en_n), .up_dn(up_dn), .oe_n(oe_n),
    .op(op), .load_sel(load_sel), .bus_oe(bus_oe)
  );

  bmc_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .op(op), .din(bus_in), .count(count)
  );

  bmc_term #(.W(W)) u_term (
    .count(count), .up_dn(up_dn), .chain_en_n(chain_en_n), .tc_n(tc_n)
  );

  assign bus_out = count;

  // R4
  no_drive_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_sel |-> !bus_oe);
  // R4
  drive_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (!sel_n && !oe_n));
  // R8
  tc_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chain_en_n |-> tc_n);
  // R8
  tc_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tc_n |-> (count == (up_dn ? TOP : '0)));
endmodule

// File: tb/bmc_counter_test.sv
module bmc_counter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0, sclr_n = 1'b1, sel_n = 1'b0, ld_n = 1'b1;
  logic       cnt_en_n = 1'b1, chain_en_n = 1'b1, up_dn = 1'b1, oe_n = 1'b0;
  logic [7:0] bus_in = '0;
  logic [7:0] bus_out;
  logic       bus_oe, tc_n;
  int         errs = 0, checks = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  bmc_counter #(.W(8)) uut (
    .clk(clk), .rst_n(rst_n), .sclr_n(sclr_n), .sel_n(sel_n), .ld_n(ld_n),
    .cnt_en_n(cnt_en_n), .chain_en_n(chain_en_n), .up_dn(up_dn), .oe_n(oe_n),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .tc_n(tc_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at falling edge, sample 1 ns after the next rising edge
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    @(negedge clk);
    sclr_n = 1; sel_n = 0; ld_n = 1; cnt_en_n = 1; chain_en_n = 1; oe_n = 0;
  endtask

  task automatic load(input logic [7:0] v);
    @(negedge clk); sel_n = 0; ld_n = 0; bus_in = v;
    tick();
    @(negedge clk); ld_n = 1;
  endtask

  task automatic t_reset();
    #1; chk("R1 count in reset", bus_out, 8'h00);
    @(negedge clk); rst_n = 1;
    tick(); chk("R4 drive on read", {7'd0, bus_oe}, 8'd1);
  endtask

  task automatic t_bus_rules();
    @(negedge clk); sel_n = 0; ld_n = 0; bus_in = 8'h5A; #0.5;
    chk("R4 no drive while load selected", {7'd0, bus_oe}, 8'd0);
    tick();
    @(negedge clk); ld_n = 1; #0.5;
    chk("R3 load value", bus_out, 8'h5A);
    chk("R4 drive after load", {7'd0, bus_oe}, 8'd1);
    oe_n = 1; #0.5; chk("R4 oe_n high releases", {7'd0, bus_oe}, 8'd0);
    oe_n = 0; sel_n = 1; #0.5; chk("R4 sel_n high releases", {7'd0, bus_oe}, 8'd0);
  endtask

  task automatic t_sel_gate();
    @(negedge clk); sel_n = 1; ld_n = 0; bus_in = 8'h11;
    tick(); chk("R5 no load when unselected", bus_out, 8'h5A);
    @(negedge clk); cnt_en_n = 0; chain_en_n = 0; up_dn = 1;
    tick(); chk("R5 counts despite ld_n", bus_out, 8'h5B);
    idle();
  endtask

  task automatic t_sclr();
    @(negedge clk); sclr_n = 0; sel_n = 0; ld_n = 0; bus_in = 8'h33;
    cnt_en_n = 0; chain_en_n = 0;
    tick(); chk("R2 clear beats load", bus_out, 8'h00);
    idle();
  endtask

  task automatic t_up();
    load(8'hFD);
    @(negedge clk); cnt_en_n = 0; chain_en_n = 0; up_dn = 1;
    tick(); chk("R7 up", bus_out, 8'hFE);
    #0.5; chk("R8 tc high before end", {7'd0, tc_n}, 8'd1);
    tick(); chk("R7 up to top", bus_out, 8'hFF);
    #0.5; chk("R8 tc low at top", {7'd0, tc_n}, 8'd0);
    tick(); chk("R7 wrap up", bus_out, 8'h00);
    idle();
  endtask

  task automatic t_down();
    load(8'h01);
    @(negedge clk); cnt_en_n = 0; chain_en_n = 0; up_dn = 0;
    tick(); chk("R7 down to zero", bus_out, 8'h00);
    #0.5; chk("R8 tc low at zero down", {7'd0, tc_n}, 8'd0);
    tick(); chk("R7 wrap down", bus_out, 8'hFF);
    #0.5; chk("R8 tc high at top down", {7'd0, tc_n}, 8'd1);
    idle();
  endtask

  task automatic t_hold();
    load(8'hFF);
    @(negedge clk); up_dn = 1; cnt_en_n = 1; chain_en_n = 0;
    tick(); chk("R6 hold on cnt_en_n", bus_out, 8'hFF);
    chk("R8 tc ignores cnt_en_n", {7'd0, tc_n}, 8'd0);
    @(negedge clk); cnt_en_n = 0; chain_en_n = 1;
    tick(); chk("R6 hold on chain_en_n", bus_out, 8'hFF);
    chk("R8 tc forced high", {7'd0, tc_n}, 8'd1);
    idle();
  endtask

  task automatic t_async();
    load(8'h77);
    @(negedge clk); #0.5; rst_n = 0; #0.5;
    chk("R1 async clear between edges", bus_out, 8'h00);
    sel_n = 0; ld_n = 0; bus_in = 8'h99;
    tick(); chk("R1 clear holds over load", bus_out, 8'h00);
    @(negedge clk); rst_n = 1; ld_n = 1;
  endtask

  initial begin
    fork
      begin
        t_reset(); t_bus_rules(); t_sel_gate(); t_sclr();
        t_up(); t_down(); t_hold(); t_async();
      end
      begin
        repeat (5000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule